// File: doc/BRIEF.md
# Duty-Cycled Conversion Ratio Stepper

This block keeps the conversion ratio of a charge pump and raises it while energy is being moved from a buffer capacitor into a battery. The pump starts each transfer at its lowest ratio. As the buffer drains, its voltage falls, and the pump needs a higher ratio to stay efficient.

The stepper does not evaluate every clock. It opens a short evaluation window once per fixed number of system clocks. During that window it raises an enable to an external scaled-voltage amplifier and comparator. On the following clock it reads the comparator's answer. A "below threshold" answer moves the ratio up by exactly one step. Any other answer leaves the ratio unchanged. The enable then drops straight away, so the analog path is powered only for the one cycle it needs to settle.

The ratio never decreases during a transfer and never goes beyond its upper limit. An initialize strobe at the start of each transfer puts the ratio back to its lowest value and restarts the evaluation schedule.

Top module: `ratio_stepper`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `eval_en` is 0 and `ratio` is 10.
- R2: While `xfer_active` stays 1 and `init_pulse` stays 0, `eval_en` is a one-cycle pulse that repeats every 3 cycles. The first pulse appears in the 3rd cycle after activity begins (counting from a reset, an initialize, or a return of `xfer_active`). `eval_en` is never high on two cycles in a row.
- R3: `cmp_below` (1 = scaled input below threshold) is read only at the clock edge that ends a cycle in which `eval_en` is 1. If it reads 1, `ratio` becomes the old value plus one at that edge. Its value in any other cycle has no effect on `ratio`.
- R4: If `cmp_below` is 0 at the decision edge, `ratio` keeps its value.
- R5: `ratio` stays within 10 to 20. When it is at 20, a "below" decision leaves it at 20; it never wraps.
- R6: `init_pulse` = 1 at an edge loads `ratio` with 10, clears `eval_en` and restarts the 3-cycle schedule. It takes priority over a pending decision.
- R7: While `xfer_active` is 0, `eval_en` is 0 from the next edge on and `ratio` holds its value, whatever `cmp_below` does.
- R8: If `xfer_active` is 0 at a decision edge, that decision is dropped and `ratio` is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_active | input | 1 | 1 while the transfer mode is running |
| init_pulse | input | 1 | Initialize strobe: reload minimum ratio, restart schedule |
| cmp_below | input | 1 | Comparator result, 1 = scaled input below threshold |
| eval_en | output | 1 | Enable to the scaled-voltage amplifier for one evaluation |
| ratio | output | 5 | Current conversion ratio, 10 to 20 |

## Verification
The assertions assume that reset is held until the first clock edge. They also assume that `init_pulse` and `xfer_active` are clean synchronous levels. They do not assume that the comparator is quiet outside the evaluation window. For that reason the bench toggles `cmp_below` freely, including a pattern that asserts it only outside the window. The bench drops `xfer_active` and raises `init_pulse` exactly in a decision cycle, so the priority and drop rules are exercised at their edges. All stimulus changes on the falling clock edge, so every input is stable around the rising edge.

// File: rtl/crs_pkg.sv
package crs_pkg;
   // Default geometry of the stepper
   localparam int unsigned CRS_RATIO_W   = 5;
   localparam int unsigned CRS_RATIO_MIN = 10;
   localparam int unsigned CRS_RATIO_MAX = 20;
   localparam int unsigned CRS_PERIOD    = 3;

   // Width that holds a count of 0 .. n-1 (at least one bit)
   function automatic int unsigned crs_cnt_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/crs_slot_timer.sv
module crs_slot_timer #(
   parameter int unsigned PERIOD = crs_pkg::CRS_PERIOD
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic slot
);
   localparam int unsigned CNT_W = crs_pkg::crs_cnt_width(PERIOD);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             slot_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         slot_q <= 1'b0;
      end else if (restart || !run) begin
         cnt_q  <= '0;
         slot_q <= 1'b0;
      end else if (cnt_q == LAST) begin
         cnt_q  <= '0;
         slot_q <= 1'b1;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
         slot_q <= 1'b0;
      end
   end

   assign slot = slot_q;
endmodule

// File: rtl/crs_ratio_reg.sv
module crs_ratio_reg #(
   parameter int unsigned RATIO_W   = crs_pkg::CRS_RATIO_W,
   parameter int unsigned RATIO_MIN = crs_pkg::CRS_RATIO_MIN,
   parameter int unsigned RATIO_MAX = crs_pkg::CRS_RATIO_MAX
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               step,
   output logic [RATIO_W-1:0] ratio
);
   localparam logic [RATIO_W-1:0] LO = RATIO_W'(RATIO_MIN);
   localparam logic [RATIO_W-1:0] HI = RATIO_W'(RATIO_MAX);

   logic [RATIO_W-1:0] ratio_q;
   logic               at_top;

   assign at_top = (ratio_q >= HI);

   always_ff @(posedge clk) begin
      if (!rst_n)
         ratio_q <= LO;
      else if (load)
         ratio_q <= LO;
      else if (step && !at_top)
         ratio_q <= ratio_q + 1'b1;
   end

   assign ratio = ratio_q;
endmodule

// File: rtl/ratio_stepper.sv
module ratio_stepper #(
   parameter int unsigned RATIO_W   = crs_pkg::CRS_RATIO_W,
   parameter int unsigned RATIO_MIN = crs_pkg::CRS_RATIO_MIN,
   parameter int unsigned RATIO_MAX = crs_pkg::CRS_RATIO_MAX,
   parameter int unsigned PERIOD    = crs_pkg::CRS_PERIOD
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               xfer_active,
   input  logic               init_pulse,
   input  logic               cmp_below,
   output logic               eval_en,
   output logic [RATIO_W-1:0] ratio
);
   // Elaboration-time parameter checks
   if (RATIO_MIN >= RATIO_MAX) begin : g_bad_range
      $error("ratio_stepper: RATIO_MIN must be below RATIO_MAX");
   end
   if (RATIO_MAX >= (1 << RATIO_W)) begin : g_bad_width
      $error("ratio_stepper: RATIO_W too narrow for RATIO_MAX");
   end
   if (PERIOD < 2) begin : g_bad_period
      $error("ratio_stepper: PERIOD must leave a gap after each pulse");
   end

   logic slot;
   logic step;

   crs_slot_timer #(.PERIOD(PERIOD)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (xfer_active),
      .restart (init_pulse),
      .slot    (slot)
   );

   // Decision: taken on the edge closing the enabled cycle
   assign step = slot && xfer_active && cmp_below && !init_pulse;

   crs_ratio_reg #(
      .RATIO_W   (RATIO_W),
      .RATIO_MIN (RATIO_MIN),
      .RATIO_MAX (RATIO_MAX)
   ) u_ratio (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (init_pulse),
      .step  (step),
      .ratio (ratio)
   );

   assign eval_en = slot;
endmodule

// File: rtl/crs_stepper_chk.sv
module crs_stepper_chk #(
   parameter int unsigned RATIO_W   = 5,
   parameter int unsigned RATIO_MIN = 10,
   parameter int unsigned RATIO_MAX = 20
) (
   input logic               clk,
   input logic               rst_n,
   input logic               xfer_active,
   input logic               init_pulse,
   input logic               cmp_below,
   input logic               eval_en,
   input logic [RATIO_W-1:0] ratio
);
   // R2: enable is a single-cycle pulse
   p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      eval_en |=> !eval_en);

   // R5: ratio stays inside its range
   p_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio >= RATIO_W'(RATIO_MIN)) && (ratio <= RATIO_W'(RATIO_MAX)));

   // R3: ratio moves up by at most one per edge
   p_unit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !init_pulse |=> (ratio == $past(ratio)) || (ratio == $past(ratio) + 1'b1));

   // R4: no decision in progress means no change
   p_hold_no_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_pulse && !(eval_en && cmp_below)) |=> $stable(ratio));

   // R6: initialize reloads the minimum and clears the enable
   p_init_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      init_pulse |=> (ratio == RATIO_W'(RATIO_MIN)) && !eval_en);

   // R7: idle transfer keeps the enable low and the ratio still
   p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer_active && !init_pulse) |=> !eval_en && $stable(ratio));
endmodule

bind ratio_stepper crs_stepper_chk #(
   .RATIO_W   (RATIO_W),
   .RATIO_MIN (RATIO_MIN),
   .RATIO_MAX (RATIO_MAX)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .xfer_active (xfer_active),
   .init_pulse  (init_pulse),
   .cmp_below   (cmp_below),
   .eval_en     (eval_en),
   .ratio       (ratio)
);

// File: tb/test_ratio_stepper.sv
module test_ratio_stepper;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       xfer_active = 1'b0;
   logic       init_pulse = 1'b0;
   logic       cmp_below = 1'b0;
   logic       eval_en;
   logic [4:0] ratio;

   int n_checks = 0;
   int n_errors = 0;

   // Scoreboard queues: expected outputs after the coming rising edge
   bit    q_eval[$];
   int    q_ratio[$];
   string q_tag[$];

   // Bench-side expectation state, derived from the requirements
   int m_cnt = 0;
   bit m_eval = 1'b0;
   int m_ratio = 10;

   always #5 clk = ~clk;

   ratio_stepper i_ratio_stepper (
      .clk         (clk),
      .rst_n       (rst_n),
      .xfer_active (xfer_active),
      .init_pulse  (init_pulse),
      .cmp_below   (cmp_below),
      .eval_en     (eval_en),
      .ratio       (ratio)
   );

   task automatic check(bit ge, int gr, bit ee, int er, string tag);
      n_checks++;
      if (ge !== ee || gr != er) begin
         n_errors++;
         $display("FAIL %s: eval_en=%0d ratio=%0d expected eval_en=%0d ratio=%0d",
                  tag, ge, gr, ee, er);
      end
   endtask

   // Driver: apply one cycle of stimulus and queue the expected result
   task automatic drive(bit x, bit i, bit b, string tag);
      @(negedge clk);
      xfer_active = x;
      init_pulse  = i;
      cmp_below   = b;
      if (i) begin                       // R6
         m_ratio = 10; m_cnt = 0; m_eval = 1'b0;
      end else if (!x) begin             // R7, R8
         m_cnt = 0; m_eval = 1'b0;
      end else begin
         if (m_eval && b && m_ratio < 20) m_ratio++;   // R3, R4, R5
         if (m_cnt == 2) begin m_cnt = 0; m_eval = 1'b1; end   // R2
         else begin m_cnt++; m_eval = 1'b0; end
      end
      q_eval.push_back(m_eval);
      q_ratio.push_back(m_ratio);
      q_tag.push_back(tag);
   endtask

   // Monitor: compare after each rising edge, away from it
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q_tag.size() > 0) begin
            bit    e_ev;
            int    e_ra;
            string t;
            e_ev = q_eval.pop_front();
            e_ra = q_ratio.pop_front();
            t    = q_tag.pop_front();
            check(eval_en, int'(ratio), e_ev, e_ra, t);
         end
      end
   end

   // Watchdog
   initial begin
      #500000;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      // R1: state under reset and right after release
      repeat (3) @(negedge clk);
      check(eval_en, int'(ratio), 1'b0, 10, "R1 in reset");
      rst_n = 1'b1;
      @(posedge clk); #2;
      check(eval_en, int'(ratio), 1'b0, 10, "R1 after release");

      // R2, R3, R5: climb to the top with below=1 and saturate
      for (int k = 0; k < 40; k++) drive(1, 0, 1, "R2/R3/R5 climb");

      // R6: initialize back to minimum
      drive(1, 1, 1, "R6 init");

      // R4: comparator says not below
      for (int k = 0; k < 9; k++) drive(1, 0, 0, "R4 hold");

      // R3: below only outside the window, must be ignored
      for (int k = 0; k < 12; k++) drive(1, 0, !m_eval, "R3 off-slot ignored");

      // R3: alternating comparator
      for (int k = 0; k < 12; k++) drive(1, 0, k[0], "R3 alternating");

      // R7: transfer idle with comparator high
      for (int k = 0; k < 7; k++) drive(0, 0, 1, "R7 idle");
      for (int k = 0; k < 6; k++) drive(1, 0, 1, "R7 restart");

      // R8: drop transfer exactly at a decision edge
      while (!m_eval) drive(1, 0, 1, "R8 approach");
      drive(0, 0, 1, "R8 dropped decision");
      drive(0, 0, 1, "R8 idle");
      for (int k = 0; k < 4; k++) drive(1, 0, 1, "R8 resume");

      // R6: initialize wins over a pending decision
      while (!m_eval) drive(1, 0, 1, "R6 approach");
      drive(1, 1, 1, "R6 init priority");
      for (int k = 0; k < 5; k++) drive(1, 0, 0, "R6 schedule restart");

      drive(0, 0, 0, "R7 final idle");
      @(posedge clk); #3;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule